// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, A and B, through a path that can run in either direction. Each direction has a storage register of its own, loaded by its own capture pulse. A per-direction select chooses what the receiving bus gets: the live value from the opposite bus, or the copy held in that direction's register. In both cases the data reaches the pins bitwise inverted.

The active-low enable and the direction input decide which bus is driven. At most one bus is driven at a time. When the enable is off, both buses are isolated. Captures take place whatever the enable and the direction are, so the block can also act as a pair of bus-snooping registers.

Tri-state pins appear as separate input, output and per-bit output-enable vectors for each bus. The two capture "clocks" are single-cycle enable pulses sampled in one system clock domain.

Top module: `regxcvr`

## Requirements
- R1: When `cap_ab` is high at a rising `clk` edge (reset released), the A-to-B register loads `a_in`. The register loads whatever the values of `oe_n` and `dir`.
- R2: When `cap_ba` is high at a rising `clk` edge (reset released), the B-to-A register loads `b_in`. The register loads whatever the values of `oe_n` and `dir`.
- R3: A register keeps its value over any edge at which its own capture pulse is low.
- R4: With `sel_ab`=0, `b_out` equals `~a_in` in the same cycle. With `sel_ab`=1, `b_out` equals the inverse of the A-to-B register; a value loaded at an edge shows up right after that edge.
- R5: With `sel_ba`=0, `a_out` equals `~b_in` in the same cycle. With `sel_ba`=1, `a_out` equals the inverse of the B-to-A register.
- R6: With `oe_n`=1, both `a_oe` and `b_oe` are all zeros (isolation).
- R7: With `oe_n`=0 and `dir`=0, `a_oe` is all ones and `b_oe` is all zeros (B drives A).
- R8: With `oe_n`=0 and `dir`=1, `b_oe` is all ones and `a_oe` is all zeros (A drives B).
- R9: While `rst_n` is low, both enable vectors are zero and both registers are cleared asynchronously. After release, a stored-path output reads all ones until its register is loaded.
- R10: `a_oe` and `b_oe` are never nonzero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: A drives B, 0: B drives A |
| cap_ab | input | 1 | Capture pulse for the A-to-B register |
| cap_ba | input | 1 | Capture pulse for the B-to-A register |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored |
| a_in | input | W | Value seen on bus A |
| b_in | input | W | Value seen on bus B |
| a_out | output | W | Value to drive on bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_out | output | W | Value to drive on bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The assertions check four things on every cycle: that the buses are never both driven, that isolation and reset disable both sides, that live selection yields the inverse of the opposite input, and that a stored output follows a capture or holds without one. Other behaviour can only be shown by the bench's scenarios, which compare the block with a reference model. This covers captures made while the buses are isolated and later read back, a reset in the middle of a run clearing data that was already stored, and the choice of direction across random mixes of select and enable values.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] st_ab, st_ba;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_ab <= '0;
    else if (cap_ab) st_ab <= a_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_ba <= '0;
    else if (cap_ba) st_ba <= b_in;

  logic drive_a, drive_b;
  assign drive_a = rst_n & ~oe_n & ~dir;
  assign drive_b = rst_n & ~oe_n &  dir;

  assign b_out = ~(sel_ab ? st_ab : a_in);
  assign a_out = ~(sel_ba ? st_ba : b_in);
  assign a_oe  = {W{drive_a}};
  assign b_oe  = {W{drive_b}};
endmodule

module regxcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_n,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);
  p_one_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  p_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  always @* begin
    if (!rst_n) p_reset_off_r9: assert (a_oe == '0 && b_oe == '0);
  end

  p_live_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ab |-> b_out == ~a_in);

  p_live_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ba |-> a_out == ~b_in);

  p_load_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cap_ab) && sel_ab) |-> b_out == ~$past(a_in));

  p_load_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cap_ba) && sel_ba) |-> a_out == ~$past(b_in));

  p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cap_ab) && $past(sel_ab) && sel_ab) |-> $stable(b_out));
endmodule

bind regxcvr regxcvr_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/regxcvr_tb_top.sv
module regxcvr_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n, oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
  logic [W-1:0] m_ab, m_ba;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  regxcvr #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab),
    .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] exp_aoe();
    return {W{rst_n & ~oe_n & ~dir}};
  endfunction
  function automatic logic [W-1:0] exp_boe();
    return {W{rst_n & ~oe_n & dir}};
  endfunction
  function automatic logic [W-1:0] exp_bout();
    return sel_ab ? ~m_ab : ~a_in;
  endfunction
  function automatic logic [W-1:0] exp_aout();
    return sel_ba ? ~m_ba : ~b_in;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(sel_ab ? "R1 R3 R4 stored b_out" : "R4 live b_out", b_out, exp_bout());
    chk(sel_ba ? "R2 R3 R5 stored a_out" : "R5 live a_out", a_out, exp_aout());
    chk(!rst_n ? "R9 a_oe" : oe_n ? "R6 a_oe" : dir ? "R8 R10 a_oe" : "R7 a_oe", a_oe, exp_aoe());
    chk(!rst_n ? "R9 b_oe" : oe_n ? "R6 b_oe" : dir ? "R8 b_oe" : "R7 R10 b_oe", b_oe, exp_boe());
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    if (rst_n) begin
      if (cap_ab) m_ab = a_in;
      if (cap_ba) m_ba = b_in;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic o, d, ca, cb, sa, sb, input logic [W-1:0] a, b);
    oe_n = o; dir = d; cap_ab = ca; cap_ba = cb; sel_ab = sa; sel_ba = sb;
    a_in = a; b_in = b;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5a17));
    m_ab = '0; m_ba = '0;
    rst_n = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C);
    @(negedge clk);
    // R9: outputs off and registers cleared while reset is held
    step();
    step();
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22);
    #1 chk("R9 cleared b_out", b_out, 8'hFF);
    chk("R9 cleared a_out", a_out, 8'hFF);
    @(negedge clk);
    // R1 R2: capture while isolated, then read back with outputs enabled
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, 8'h5E);
    step();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF);
    #1 chk("R1 isolated capture b_out", b_out, 8'h3C);
    chk("R8 b_oe", b_oe, 8'hFF);
    dir = 1'b0;
    #1 chk("R2 isolated capture a_out", a_out, 8'hA1);
    chk("R7 a_oe", a_oe, 8'hFF);
    @(negedge clk);
    // R3: no pulse keeps the stored value despite new inputs
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h88);
    step();
    #1 chk("R3 hold b_out", b_out, 8'h3C);
    chk("R3 hold a_out", a_out, 8'hA1);
    @(negedge clk);
    // R4 R5: live path
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F, 8'hF0);
    #1 chk("R4 live b_out", b_out, 8'hF0);
    chk("R5 live a_out", a_out, 8'h0F);
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            W'($urandom), W'($urandom));
      if (i % 701 == 700) begin
        rst_n = 1'b0;
        #1 m_ab = '0; m_ba = '0;
        check_all();
        @(negedge clk);
        rst_n = 1'b1;
      end
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule